// File: doc/BRIEF.md
# Ethernet PHY Power-Mode Controller

This block is the digital power-management controller of a 10/100 Ethernet transceiver. It holds the three management bits that select power behaviour (full power-down, automatic receive power saving and transmit high-impedance). It combines them with a power-down pin, the current line speed and a line-activity indication, and from these it produces registered enable outputs. Those outputs steer the analog receive path, the RX clock, the transmit line drivers and the TX clock pad.

The management bits sit behind a small synchronous register port that keeps working while the chip is powered down. The line-activity input arrives from the analog domain and passes through a two-flop synchroniser before it gates anything. Power-down overrides every other mode. The transmit high-impedance bit is sticky: only a register write or a reset clears it.

Top module: `phy_pwr_ctrl`

## Requirements
- R1: `chip_pd` is high one clock after either the power-down bit (address 0, bit 11) is set or `pd_pin` is high.
- R2: While `chip_pd` is high, `rx_path_en`, `rx_clk_en`, `txclk_oe` and `txclk_pu_en` are low and `tx_drv_hiz` is high.
- R3: A write with `reg_wr` high stores bit 11 at address 0 and bits 0 and 12 at address 16. `reg_rdata` returns the stored bits of the address presented one clock earlier, with every other bit and every other address reading 0. This holds during power-down too.
- R4: With receive power saving on (address 16, bit 0) at 100 Mb/s (`speed_100`=1), `rx_path_en` and `rx_clk_en` follow `sig_present` with a latency of three clock edges.
- R5: At 10 Mb/s (`speed_100`=0), `rx_path_en` and `rx_clk_en` stay high outside power-down, whatever the receive power-saving bit and `sig_present` are.
- R6: With the transmit high-impedance bit (address 16, bit 12) set and outside power-down, `tx_drv_hiz`=1, `txclk_oe`=0 and `txclk_pu_en`=1. The receive enables are not affected.
- R7: The transmit high-impedance bit keeps its value through power-down. Only a write of 0 or a reset clears it.
- R8: One clock after both power-down sources are gone, the enables implied by the current register bits are restored.
- R9: Reset (`rst_n` low at a clock edge) clears all register bits and `reg_rdata`. It sets the outputs to `chip_pd`=0, `rx_path_en`=1, `rx_clk_en`=1, `tx_drv_hiz`=0, `txclk_oe`=1, `txclk_pu_en`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Registered read data |
| pd_pin | input | 1 | Power-down pin, synchronous to clk |
| speed_100 | input | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| sig_present | input | 1 | Asynchronous valid-line-signal indication |
| chip_pd | output | 1 | Chip-wide power-down |
| rx_path_en | output | 1 | Receive path power enable |
| rx_clk_en | output | 1 | RX clock enable |
| tx_drv_hiz | output | 1 | Transmit line drivers high-impedance |
| txclk_oe | output | 1 | TX clock output enable |
| txclk_pu_en | output | 1 | TX clock weak pull-up enable |

## Verification
The assertions take for granted that `pd_pin`, `speed_100` and the register port are synchronous to `clk`. Only `sig_present` may change at any time. They also assume that reset is held for at least two edges, so a reset-driven clear of the high-impedance bit is never mistaken for a write. The bench changes every input half a cycle away from the rising edge, holds reset for three edges, and toggles `sig_present` only while receive power saving is enabled, so that its three-edge latency can be observed.

// File: rtl/phy_pwr_pkg.sv
// Package: shared constants and the enable bundle of the power-mode controller.
// Assumes register addresses fit in 5 bits and data is at least 13 bits wide.
package phy_pwr_pkg;
    parameter int ADDR_W = 5;
    parameter int DATA_W = 16;

    localparam int CTRL_ADDR = 0;
    localparam int AUX_ADDR  = 16;
    localparam int PD_POS    = 11;
    localparam int RXPS_POS  = 0;
    localparam int TXHIZ_POS = 12;

    typedef struct packed {
        logic chip_pd;
        logic rx_path_en;
        logic rx_clk_en;
        logic tx_drv_hiz;
        logic txclk_oe;
        logic txclk_pu_en;
    } pwr_en_t;

    localparam pwr_en_t EN_RESET = '{chip_pd: 1'b0, rx_path_en: 1'b1, rx_clk_en: 1'b1,
                                     tx_drv_hiz: 1'b0, txclk_oe: 1'b1, txclk_pu_en: 1'b0};
endpackage

// File: rtl/phy_pwr_regs.sv
// Module: management bits behind a synchronous register port.
// Stores the power-down, receive power-saving and transmit high-impedance bits.
// Read data is registered: it reflects the address presented one clock earlier.
// Assumes reg port signals are synchronous to clk.
module phy_pwr_regs
    import phy_pwr_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          pd_bit,
    output logic          rxps_bit,
    output logic          txhiz_bit
);
    localparam logic [AW-1:0] A_CTRL = AW'(CTRL_ADDR);
    localparam logic [AW-1:0] A_AUX  = AW'(AUX_ADDR);

    logic          hit_ctrl, hit_aux;
    logic [DW-1:0] rd_mux;
    logic          unused_wdata;

    assign hit_ctrl     = (addr == A_CTRL);
    assign hit_aux      = (addr == A_AUX);
    assign unused_wdata = ^wdata;

    // Purpose: update the stored mode bits on a matching write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pd_bit    <= 1'b0;
            rxps_bit  <= 1'b0;
            txhiz_bit <= 1'b0;
        end else if (wr) begin
            if (hit_ctrl) pd_bit <= wdata[PD_POS];
            if (hit_aux) begin
                rxps_bit  <= wdata[RXPS_POS];
                txhiz_bit <= wdata[TXHIZ_POS];
            end
        end
    end

    // Purpose: place stored bits at their positions for the addressed register.
    always_comb begin
        rd_mux = '0;
        if (hit_ctrl) rd_mux[PD_POS] = pd_bit;
        if (hit_aux) begin
            rd_mux[RXPS_POS]  = rxps_bit;
            rd_mux[TXHIZ_POS] = txhiz_bit;
        end
    end

    // Purpose: register the read data.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else        rdata <= rd_mux;
    end

    // R7: the high-impedance bit falls only after a clearing write
    a_r7_hiz_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(txhiz_bit) && $past(rst_n)) |->
            $past(wr && hit_aux && !wdata[TXHIZ_POS]));

    // R3: a write to an address holding the bit stores the written value
    a_r3_pd_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && hit_ctrl) |=> (pd_bit == $past(wdata[PD_POS])));
endmodule

// File: rtl/phy_pwr_sync.sv
// Module: multi-stage synchroniser for a single asynchronous level.
// Assumes the input is a slow level, so no pulse shorter than a clock matters.
module phy_pwr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            // Purpose: one flop of the synchroniser chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[i] <= 1'b0;
                else        chain[i] <= (i == 0) ? d : chain[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/phy_pwr_gate.sv
// Module: combines mode bits, pin, speed and line activity into registered enables.
// Power-down overrides every other mode. The signal-present input must already be
// synchronised. All outputs change one clock after their inputs.
module phy_pwr_gate
    import phy_pwr_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    pd_bit,
    input  logic    pd_pin,
    input  logic    rxps_bit,
    input  logic    txhiz_bit,
    input  logic    speed_100,
    input  logic    sig_ok,
    output pwr_en_t en_q
);
    pwr_en_t en_d;
    logic    pd_req;
    logic    rx_on;

    assign pd_req = pd_bit | pd_pin;
    // Receive saving applies only at 100 Mb/s and only without line activity.
    assign rx_on  = !(rxps_bit && speed_100) || sig_ok;

    // Purpose: derive the next set of enables, power-down first.
    always_comb begin
        if (pd_req) begin
            en_d = '{chip_pd: 1'b1, rx_path_en: 1'b0, rx_clk_en: 1'b0,
                     tx_drv_hiz: 1'b1, txclk_oe: 1'b0, txclk_pu_en: 1'b0};
        end else begin
            en_d.chip_pd     = 1'b0;
            en_d.rx_path_en  = rx_on;
            en_d.rx_clk_en   = rx_on;
            en_d.tx_drv_hiz  = txhiz_bit;
            en_d.txclk_oe    = !txhiz_bit;
            en_d.txclk_pu_en = txhiz_bit;
        end
    end

    // Purpose: register the enables.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= EN_RESET;
        else        en_q <= en_d;
    end

    // R1: a power-down request shows on chip_pd one clock later
    a_r1_pd_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_bit || pd_pin) |=> en_q.chip_pd);

    // R2: power-down turns every circuit enable off
    a_r2_all_off: assert property (@(posedge clk) disable iff (!rst_n)
        en_q.chip_pd |-> (!en_q.rx_path_en && !en_q.rx_clk_en && !en_q.txclk_oe
                          && !en_q.txclk_pu_en && en_q.tx_drv_hiz));

    // R5: at 10 Mb/s the receive path stays powered
    a_r5_10m_rx_on: assert property (@(posedge clk) disable iff (!rst_n)
        (!pd_bit && !pd_pin && !speed_100) |=> (en_q.rx_path_en && en_q.rx_clk_en));

    // R6: high-impedance mode tri-states TX and enables the pull-up
    a_r6_hiz: assert property (@(posedge clk) disable iff (!rst_n)
        (txhiz_bit && !pd_bit && !pd_pin) |=>
            (en_q.tx_drv_hiz && !en_q.txclk_oe && en_q.txclk_pu_en));

    // R8: leaving power-down releases chip_pd on the next clock
    a_r8_restore: assert property (@(posedge clk) disable iff (!rst_n)
        (!pd_bit && !pd_pin) |=> !en_q.chip_pd);
endmodule

// File: rtl/phy_pwr_ctrl.sv
// Module: top of the PHY power-mode controller.
// Connects the register port, the signal-present synchroniser and the enable
// logic. Assumes all inputs except sig_present are synchronous to clk.
module phy_pwr_ctrl
    import phy_pwr_pkg::*;
#(
    parameter int AW          = ADDR_W,
    parameter int DW          = DATA_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          pd_pin,
    input  logic          speed_100,
    input  logic          sig_present,
    output logic          chip_pd,
    output logic          rx_path_en,
    output logic          rx_clk_en,
    output logic          tx_drv_hiz,
    output logic          txclk_oe,
    output logic          txclk_pu_en
);
    logic    pd_bit, rxps_bit, txhiz_bit, sig_ok;
    pwr_en_t en;

    phy_pwr_regs #(.AW(AW), .DW(DW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .pd_bit   (pd_bit),
        .rxps_bit (rxps_bit),
        .txhiz_bit(txhiz_bit)
    );

    phy_pwr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (sig_present),
        .q    (sig_ok)
    );

    phy_pwr_gate u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .pd_bit   (pd_bit),
        .pd_pin   (pd_pin),
        .rxps_bit (rxps_bit),
        .txhiz_bit(txhiz_bit),
        .speed_100(speed_100),
        .sig_ok   (sig_ok),
        .en_q     (en)
    );

    assign chip_pd     = en.chip_pd;
    assign rx_path_en  = en.rx_path_en;
    assign rx_clk_en   = en.rx_clk_en;
    assign tx_drv_hiz  = en.tx_drv_hiz;
    assign txclk_oe    = en.txclk_oe;
    assign txclk_pu_en = en.txclk_pu_en;
endmodule

// File: tb/phy_pwr_ctrl_tb.sv
// Bench: scoreboard. Driver tasks push expected items, a monitor pops and compares.
// Enable vector order: {chip_pd, rx_path_en, rx_clk_en, tx_drv_hiz, txclk_oe, txclk_pu_en}.
module phy_pwr_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        pd_pin = 1'b0, speed_100 = 1'b1, sig_present = 1'b0;
    logic        chip_pd, rx_path_en, rx_clk_en, tx_drv_hiz, txclk_oe, txclk_pu_en;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        bit          is_rd;
        logic [15:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    localparam logic [5:0] E_RST  = 6'b011010;
    localparam logic [5:0] E_RXOF = 6'b000010;
    localparam logic [5:0] E_HIZ  = 6'b011101;
    localparam logic [5:0] E_PD   = 6'b100100;

    always #10 clk = ~clk;

    phy_pwr_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pd_pin(pd_pin),
        .speed_100(speed_100), .sig_present(sig_present), .chip_pd(chip_pd),
        .rx_path_en(rx_path_en), .rx_clk_en(rx_clk_en), .tx_drv_hiz(tx_drv_hiz),
        .txclk_oe(txclk_oe), .txclk_pu_en(txclk_pu_en)
    );

    // Monitor: compare every queued expectation shortly after each rising edge.
    always @(posedge clk) begin
        item_t it;
        logic [15:0] act;
        #2;
        while (sb.size() > 0) begin
            it = sb.pop_front();
            act = it.is_rd ? reg_rdata
                           : {10'd0, chip_pd, rx_path_en, rx_clk_en, tx_drv_hiz, txclk_oe, txclk_pu_en};
            checks++;
            if (act !== it.exp) begin
                failures++;
                $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    task automatic settle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic exp_en(input logic [5:0] e, input string tag);
        item_t it;
        it.is_rd = 1'b0; it.exp = {10'd0, e}; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [4:0] a, input logic [15:0] e, input string tag);
        item_t it;
        @(negedge clk);
        reg_addr = a;
        settle(1);
        it.is_rd = 1'b1; it.exp = e; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        settle(3);
        exp_en(E_RST, "R9 enables in reset");
        rd_chk(5'd16, 16'h0000, "R9 aux bits cleared by reset");
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        do_reset();
        rd_chk(5'd0, 16'h0000, "R9 ctrl bit cleared by reset");
        settle(1); exp_en(E_RST, "R9 enables after release");

        // R3: unmapped address and bit masking
        wr(5'd5, 16'hFFFF);
        rd_chk(5'd5, 16'h0000, "R3 unmapped address reads 0");
        wr(5'd16, 16'hFFFF);
        rd_chk(5'd16, 16'h1001, "R3 aux reads only bits 0 and 12");
        wr(5'd16, 16'h0001);
        rd_chk(5'd16, 16'h0001, "R3 aux readback");

        // R4: receive saving at 100 Mb/s follows line activity
        settle(1); exp_en(E_RXOF, "R4 rx off without signal");
        @(negedge clk); sig_present = 1'b1;
        settle(2); exp_en(E_RXOF, "R4 rx still off after two edges");
        settle(1); exp_en(E_RST, "R4 rx on after three edges");
        @(negedge clk); sig_present = 1'b0;
        settle(3); exp_en(E_RXOF, "R4 rx off again after signal loss");

        // R5: 10 Mb/s ignores receive saving
        @(negedge clk); speed_100 = 1'b0;
        settle(1); exp_en(E_RST, "R5 rx stays on at 10 Mb/s");

        // R6: transmit high impedance
        wr(5'd16, 16'h1001);
        settle(1); exp_en(E_HIZ, "R6 tx hiz, pull-up, rx unaffected");

        // R1 / R2: power-down by pin, register port live
        @(negedge clk); pd_pin = 1'b1;
        settle(1); exp_en(E_PD, "R1 R2 pin power-down");
        rd_chk(5'd16, 16'h1001, "R3 R7 read during power-down");
        wr(5'd0, 16'hFFFF);
        rd_chk(5'd0, 16'h0800, "R3 ctrl write during power-down");
        @(negedge clk); pd_pin = 1'b0;
        settle(1); exp_en(E_PD, "R1 register bit keeps power-down");
        wr(5'd0, 16'h0000);
        settle(1); exp_en(E_HIZ, "R8 enables restored next clock");

        // R7: sticky bit survives power-down, clears by write or reset
        rd_chk(5'd16, 16'h1001, "R7 hiz kept through power-down");
        wr(5'd16, 16'h0001);
        settle(1); exp_en(E_RST, "R7 write clears hiz");
        rd_chk(5'd16, 16'h0001, "R7 aux after clear");
        wr(5'd16, 16'h1000);
        settle(1); exp_en(E_HIZ, "R6 hiz set again");
        do_reset();
        settle(1); exp_en(E_RST, "R7 R9 reset clears hiz");

        settle(2);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule